// File: doc/BRIEF.md
# Predicated Packed-SIMD Execute Unit

This unit executes SIMD instructions that treat an ordinary 32-bit integer register as a packed vector. It takes an instruction word, up to three source register values, the value of register v1 (the lane mask source), the previous contents of the destination register and a global saturation setting. From these it produces the destination value, the destination address, a write enable and a trap flag, all one clock after the inputs.

The element width is not in the opcode. Bit 4 of the destination specifier (instruction bit 11) selects it: 0 gives four 8-bit lanes and 1 gives two 16-bit lanes. A two-bit mode field does one of two things. It can mask lanes with v1 or with its inverse, or it can force saturation for one instruction. Lane arithmetic is limited to signed add, subtract, minimum, maximum, three-operand sums and clamping. Strided and indexed vector memory encodings raise the trap so that software can emulate them.

Top module: `simd_exec_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `rd_data`=0, `rd_addr`=0, `rd_we`=0 and `trap`=0, whatever the inputs.
- R2: Vector operations use opcode bits[6:0]=7'h57. With bit 14=0 and bit 25=0, the instruction is the two-register form. Its func6 (bits[31:26]) selects 0=add, 1=sub (rs1−rs2), 2=signed min and 3=signed max, applied per lane to `src_a` and `src_b`.
- R3: With bit 14=0 and bit 25=1, the instruction is the immediate form. Its func3 (bits[31:29]) selects 0=add, 1=sub, 2=min and 3=max. The second operand of every lane is the 8-bit immediate {bits[28:26], bits[24:20]}, sign-extended to the element width.
- R4: With bit 14=1, the instruction is the three-register form. Its func2 (bits[26:25]) selects 0 = a+b+c, 1 = c+a−b, or 2 = clamp of a to the range [b, c], computed as max(b, min(a, c)). Here a, b and c are lanes of `src_a`, `src_b` and `src_c`.
- R5: Instruction bit 11 (the MSB of rd) set to 0 gives four 8-bit lanes, and set to 1 gives two 16-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R6: When saturation is active, signed results are clamped to [−2^(W−1), 2^(W−1)−1]. Otherwise they wrap modulo 2^W.
- R7: The mode field mm is bits[13:12]. With mm=00, saturation follows `sat_global`. With mm=01, saturation is on for that instruction only. With mm=10 or mm=11, saturation follows `sat_global`.
- R8: With mm=00 or mm=01, all lanes are written. With mm=10, lane k is enabled when `mask_reg[k]`=1. With mm=11, lane k is enabled when `mask_reg[k]`=0. A disabled lane outputs the matching element of `rd_old`.
- R9: An undefined func code (func6≥4, func3≥4 or func2=3) gives `trap`=1, `rd_we`=0 and `rd_data`=0.
- R10: A vector load (opcode 7'h07) or vector store (opcode 7'h27) with bits[27:26]≠00 (strided or indexed) gives `trap`=1 and `rd_we`=0. Any other non-vector-op instruction gives `trap`=0, `rd_we`=0 and `rd_data`=0.
- R11: Outputs are registered. The values after a rising edge reflect the inputs present at that edge, and `rd_addr` is instruction bits[11:7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | Value of rs1 |
| src_b | input | 32 | Value of rs2 |
| src_c | input | 32 | Value of rs3 |
| mask_reg | input | 32 | Value of v1, the lane mask source |
| rd_old | input | 32 | Previous contents of the destination register |
| sat_global | input | 1 | Global saturation setting |
| rd_data | output | 32 | Destination value |
| rd_addr | output | 5 | Destination register specifier |
| rd_we | output | 1 | Destination write enable |
| trap | output | 1 | Illegal or unimplemented instruction |

## Verification
The bench drives operands that overflow at both signed limits, in both lane widths and in all three instruction formats. Its model shows a design that wraps where it should clamp, or that computes in the element width without guard bits, through the wrong result at 0x7F+1 or 0x80−1. Negative immediates in 16-bit lanes catch missing sign extension, and masks with alternating bits under both polarities catch a swapped inversion or a wrong lane-to-bit mapping. Undefined func codes, strided and indexed memory encodings, and foreign opcodes show whether a design writes when it must trap, or traps on instructions that belong to others.

// File: rtl/simd_exec_pkg.sv
// Package: shared constants and types of the packed-SIMD execute unit.
// Assumes a 32-bit instruction word with the major opcode in bits [6:0].
package simd_exec_pkg;
    localparam int INSN_W = 32;
    localparam int REG_AW = 5;
    localparam int IMM_W  = 8;
    localparam logic [6:0] OPC_VOP = 7'h57;
    localparam logic [6:0] OPC_VLD = 7'h07;
    localparam logic [6:0] OPC_VST = 7'h27;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_MIN    = 3'd2,
        OP_MAX    = 3'd3,
        OP_ADD3   = 3'd4,
        OP_ACCSUB = 3'd5,
        OP_CLAMP  = 3'd6
    } lane_op_e;

    typedef struct packed {
        lane_op_e           op;
        logic               imm_form;
        logic               wide;
        logic               use_mask;
        logic               inv_mask;
        logic               force_sat;
        logic               wr;
        logic               trap;
        logic [IMM_W-1:0]   imm;
        logic [REG_AW-1:0]  rd;
    } dec_t;
endpackage

// File: rtl/simd_decode.sv
// Module: simd_decode
// Decodes the instruction format, lane operation, element width, mode field
// and trap condition. Purely combinational. Assumes the source register
// values are fetched elsewhere, so the register specifier fields go unused.
module simd_decode
    import simd_exec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [6:0] opc;
    logic       op_ok;
    lane_op_e   op_sel;
    logic       unused_fields;

    assign opc           = insn[6:0];
    assign unused_fields = ^{insn[19:15]};

    // Pick the lane operation from the func field of the detected format.
    always_comb begin
        op_ok  = 1'b1;
        op_sel = OP_ADD;
        if (insn[14]) begin
            case (insn[26:25])
                2'd0:    op_sel = OP_ADD3;
                2'd1:    op_sel = OP_ACCSUB;
                2'd2:    op_sel = OP_CLAMP;
                default: op_ok  = 1'b0;
            endcase
        end else if (insn[25]) begin
            if (insn[31:29] < 3'd4) op_sel = lane_op_e'({1'b0, insn[30:29]});
            else                    op_ok  = 1'b0;
        end else begin
            if (insn[31:26] < 6'd4) op_sel = lane_op_e'({1'b0, insn[27:26]});
            else                    op_ok  = 1'b0;
        end
    end

    // Assemble the decoded control word, including memory-encoding traps.
    always_comb begin
        dec.op        = op_sel;
        dec.imm_form  = ~insn[14] & insn[25];
        dec.wide      = insn[11];
        dec.use_mask  = insn[13];
        dec.inv_mask  = insn[13] & insn[12];
        dec.force_sat = ~insn[13] & insn[12];
        dec.imm       = {insn[28:26], insn[24:20]};
        dec.rd        = insn[11:7];
        dec.wr        = (opc == OPC_VOP) & op_ok;
        dec.trap      = ((opc == OPC_VOP) & ~op_ok) |
                        (((opc == OPC_VLD) | (opc == OPC_VST)) & (insn[27:26] != 2'b00));
    end
endmodule

// File: rtl/simd_lane.sv
// Module: simd_lane
// One signed lane of width W. Computes in W+2 bits so that a sum of three
// operands cannot overflow, then either clamps or truncates to W bits.
module simd_lane
    import simd_exec_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_op_e     op,
    input  logic         sat,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    localparam int EW = W + 2;
    localparam logic signed [EW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [EW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

    logic signed [EW-1:0] ea, eb, ec, full, tmp;

    assign ea = {{2{a[W-1]}}, a};
    assign eb = {{2{b[W-1]}}, b};
    assign ec = {{2{c[W-1]}}, c};

    // Wide-precision result of the selected operation.
    always_comb begin
        tmp = (ea < ec) ? ea : ec;
        case (op)
            OP_ADD:    full = ea + eb;
            OP_SUB:    full = ea - eb;
            OP_MIN:    full = (ea < eb) ? ea : eb;
            OP_MAX:    full = (ea > eb) ? ea : eb;
            OP_ADD3:   full = ea + eb + ec;
            OP_ACCSUB: full = ec + ea - eb;
            OP_CLAMP:  full = (tmp > eb) ? tmp : eb;
            default:   full = '0;
        endcase
    end

    // Saturate to the signed range or wrap to W bits.
    always_comb begin
        if (sat && full > MAXV)      y = MAXV[W-1:0];
        else if (sat && full < MINV) y = MINV[W-1:0];
        else                         y = full[W-1:0];
    end

    // Saturated sum of two non-negative lanes never turns negative.
    always_comb begin
        if (sat && op == OP_ADD && !a[W-1] && !b[W-1]) begin
            // R6
            pos_add_sat_chk: assert (!y[W-1]);
        end
    end
endmodule

// File: rtl/simd_exec_unit.sv
// Module: simd_exec_unit
// Top of the packed-SIMD execute unit: decodes, runs narrow and wide lane
// arrays in parallel, applies the lane mask, and registers the result.
// Assumes DATA_W is a multiple of 16; the narrow and wide element widths
// are fixed at 8 and 16 by the instruction set.
module simd_exec_unit
    import simd_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  logic [DATA_W-1:0] mask_reg,
    input  logic [DATA_W-1:0] rd_old,
    input  logic              sat_global,
    output logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              rd_we,
    output logic              trap
);
    localparam int NW = 8;
    localparam int WW = 16;
    localparam int NN = DATA_W / NW;
    localparam int NWD = DATA_W / WW;

    dec_t              dec;
    logic              sat_eff;
    logic [DATA_W-1:0] res_n, res_w, mrg_n, mrg_w, result;
    logic [NN-1:0]     en_n;
    logic [NWD-1:0]    en_w;
    logic              unused_mask;

    assign unused_mask = ^mask_reg[DATA_W-1:NN];

    simd_decode u_dec (.insn(insn), .dec(dec));

    // Saturation is on when forced by the mode field or set globally.
    assign sat_eff = dec.force_sat | sat_global;

    for (genvar k = 0; k < NN; k++) begin : g_narrow
        simd_lane #(.W(NW)) u_lane (
            .op (dec.op),
            .sat(sat_eff),
            .a  (src_a[k*NW +: NW]),
            .b  (dec.imm_form ? dec.imm : src_b[k*NW +: NW]),
            .c  (src_c[k*NW +: NW]),
            .y  (res_n[k*NW +: NW])
        );
        assign en_n[k] = dec.use_mask ? (mask_reg[k] ^ dec.inv_mask) : 1'b1;
        assign mrg_n[k*NW +: NW] = en_n[k] ? res_n[k*NW +: NW] : rd_old[k*NW +: NW];
    end

    for (genvar k = 0; k < NWD; k++) begin : g_wide
        simd_lane #(.W(WW)) u_lane (
            .op (dec.op),
            .sat(sat_eff),
            .a  (src_a[k*WW +: WW]),
            .b  (dec.imm_form ? {{(WW-IMM_W){dec.imm[IMM_W-1]}}, dec.imm} : src_b[k*WW +: WW]),
            .c  (src_c[k*WW +: WW]),
            .y  (res_w[k*WW +: WW])
        );
        assign en_w[k] = dec.use_mask ? (mask_reg[k] ^ dec.inv_mask) : 1'b1;
        assign mrg_w[k*WW +: WW] = en_w[k] ? res_w[k*WW +: WW] : rd_old[k*WW +: WW];
    end

    // Pick the lane array by element width; drive zero when not writing.
    always_comb begin
        if (!dec.wr)      result = '0;
        else if (dec.wide) result = mrg_w;
        else               result = mrg_n;
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_addr <= '0;
            rd_we   <= 1'b0;
            trap    <= 1'b0;
        end else begin
            rd_data <= result;
            rd_addr <= dec.rd;
            rd_we   <= dec.wr;
            trap    <= dec.trap;
        end
    end

    // R9
    trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !rd_we);

    // R8
    masked_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr && !dec.wide && !en_n[0]) |=> (rd_data[NW-1:0] == $past(rd_old[NW-1:0])));

    // R10
    foreign_opc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[6:0] != OPC_VOP && insn[6:0] != OPC_VLD && insn[6:0] != OPC_VST)
        |=> (!rd_we && !trap && rd_data == '0));
endmodule

// File: tb/simd_exec_unit_tb.sv
// Bench: behavioural integer model of the execute unit, compared every cycle.
module simd_exec_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0, src_a = '0, src_b = '0, src_c = '0, mask_reg = '0, rd_old = '0;
    logic        sat_global = 1'b0;
    logic [31:0] rd_data;
    logic [4:0]  rd_addr;
    logic        rd_we, trap;

    int checks = 0;
    int errors = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn(insn), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .mask_reg(mask_reg), .rd_old(rd_old), .sat_global(sat_global),
        .rd_data(rd_data), .rd_addr(rd_addr), .rd_we(rd_we), .trap(trap)
    );

    function automatic logic [31:0] f_rr(input logic [5:0] f6, input logic [1:0] mm, input logic [4:0] rd);
        return {f6, 1'b0, 5'd2, 5'd1, 1'b0, mm, rd, 7'h57};
    endfunction
    function automatic logic [31:0] f_ri(input logic [2:0] f3, input logic [7:0] imm, input logic [1:0] mm, input logic [4:0] rd);
        return {f3, imm[7:5], 1'b1, imm[4:0], 5'd1, 1'b0, mm, rd, 7'h57};
    endfunction
    function automatic logic [31:0] f_r3(input logic [1:0] f2, input logic [1:0] mm, input logic [4:0] rd);
        return {5'd3, f2, 5'd2, 5'd1, 1'b1, mm, rd, 7'h57};
    endfunction

    function automatic int sx(input int x, input int w);
        return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
    endfunction

    function automatic void ref_model(input logic [31:0] ins, a, b, c, v1, old,
                                      input logic gs, output logic [31:0] d,
                                      output logic w, output logic t);
        int op, wb, n, mk, lo, hi, ea, eb, ec, r, tm;
        logic sat, immf;
        d = '0; w = 1'b0; t = 1'b0; op = -1; immf = 1'b0;
        if (ins[6:0] == 7'h57) begin
            if (ins[14]) begin
                if (ins[26:25] != 2'd3) op = 4 + int'(ins[26:25]);
            end else if (ins[25]) begin
                immf = 1'b1;
                if (ins[31:29] < 3'd4) op = int'(ins[31:29]);
            end else if (ins[31:26] < 6'd4) op = int'(ins[31:26]);
            if (op < 0) t = 1'b1;
            else begin
                w = 1'b1;
                wb = ins[11] ? 16 : 8;
                n = 32 / wb;
                mk = (1 << wb) - 1;
                lo = -(1 << (wb - 1));
                hi = (1 << (wb - 1)) - 1;
                sat = (ins[13:12] == 2'b01) ? 1'b1 : gs;
                for (int k = 0; k < n; k++) begin
                    ea = sx(int'(a >> (k*wb)) & mk, wb);
                    eb = immf ? sx(int'({ins[28:26], ins[24:20]}), 8) : sx(int'(b >> (k*wb)) & mk, wb);
                    ec = sx(int'(c >> (k*wb)) & mk, wb);
                    case (op)
                        0: r = ea + eb;
                        1: r = ea - eb;
                        2: r = (ea < eb) ? ea : eb;
                        3: r = (ea > eb) ? ea : eb;
                        4: r = ea + eb + ec;
                        5: r = ec + ea - eb;
                        default: begin
                            tm = (ea < ec) ? ea : ec;
                            r = (tm > eb) ? tm : eb;
                        end
                    endcase
                    if (sat && r > hi) r = hi;
                    if (sat && r < lo) r = lo;
                    if (ins[13] && (v1[k] == ins[12])) r = int'(old >> (k*wb));
                    d = d | ((32'(r) & 32'(mk)) << (k*wb));
                end
            end
        end else if ((ins[6:0] == 7'h07 || ins[6:0] == 7'h27) && ins[27:26] != 2'b00) begin
            t = 1'b1;
        end
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    // Apply one vector at a falling edge and compare one cycle later.
    task automatic run_vec(input string tag, input logic [31:0] ins, a, b, c, v1, old, input logic gs);
        logic [31:0] ed;
        logic ew, et;
        insn = ins; src_a = a; src_b = b; src_c = c; mask_reg = v1; rd_old = old; sat_global = gs;
        ref_model(ins, a, b, c, v1, old, gs, ed, ew, et);
        @(negedge clk);
        checks++;
        if (rd_data !== ed || rd_we !== ew || trap !== et || rd_addr !== ins[11:7]) begin
            errors++;
            $display("FAIL %s insn=%h data=%h/%h we=%b/%b trap=%b/%b addr=%h/%h (actual/expected)",
                     tag, ins, rd_data, ed, rd_we, ew, trap, et, rd_addr, ins[11:7]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: a valid add is present during reset; the outputs must stay zero.
        insn = f_rr(6'd0, 2'b00, 5'd3); src_a = 32'h0101_0101; src_b = 32'h0101_0101;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== '0 || rd_addr !== '0 || rd_we !== 1'b0 || trap !== 1'b0) begin
            errors++;
            $display("FAIL R1 data=%h addr=%h we=%b trap=%b expected all zero", rd_data, rd_addr, rd_we, trap);
        end
        rst_n = 1'b1;

        // R2: two-register form, wrapping
        run_vec("R2", f_rr(6'd0, 2'b00, 5'd3), 32'h7F80_0102, 32'h0180_03FF, 0, 0, 0, 1'b0);
        run_vec("R2", f_rr(6'd1, 2'b00, 5'd4), 32'h8000_7F10, 32'h0101_FF20, 0, 0, 0, 1'b0);
        run_vec("R2", f_rr(6'd2, 2'b00, 5'd5), 32'h807F_05FB, 32'h01FE_0504, 0, 0, 0, 1'b0);
        run_vec("R2", f_rr(6'd3, 2'b00, 5'd6), 32'h807F_05FB, 32'h01FE_0504, 0, 0, 0, 1'b0);
        // R6: global saturation clamps at both limits
        run_vec("R6", f_rr(6'd0, 2'b00, 5'd3), 32'h7F80_0102, 32'h0180_03FF, 0, 0, 0, 1'b1);
        run_vec("R6", f_rr(6'd1, 2'b00, 5'd3), 32'h8000_7F10, 32'h0101_FF20, 0, 0, 0, 1'b1);
        // R5: 16-bit lanes, wrap and saturate
        run_vec("R5", f_rr(6'd0, 2'b00, 5'h13), 32'h7FFF_8000, 32'h0001_FFFF, 0, 0, 0, 1'b0);
        run_vec("R5", f_rr(6'd0, 2'b00, 5'h13), 32'h7FFF_8000, 32'h0001_FFFF, 0, 0, 0, 1'b1);
        run_vec("R5", f_rr(6'd1, 2'b00, 5'h1F), 32'h1234_00FF, 32'h0235_0100, 0, 0, 0, 1'b0);
        // R3: immediate form with sign extension
        run_vec("R3", f_ri(3'd0, 8'hF0, 2'b00, 5'h12), 32'h0005_8005, 0, 0, 0, 0, 1'b1);
        run_vec("R3", f_ri(3'd0, 8'hF0, 2'b00, 5'h12), 32'h0005_8005, 0, 0, 0, 0, 1'b0);
        run_vec("R3", f_ri(3'd1, 8'h7F, 2'b00, 5'h02), 32'h8000_7FFF, 0, 0, 0, 0, 1'b0);
        run_vec("R3", f_ri(3'd3, 8'h80, 2'b00, 5'h02), 32'h8081_7F00, 0, 0, 0, 0, 1'b0);
        run_vec("R3", f_ri(3'd2, 8'h05, 2'b00, 5'h02), 32'h0406_FF7F, 0, 0, 0, 0, 1'b0);
        // R4: three-register form
        run_vec("R4", f_r3(2'd0, 2'b00, 5'd7), 32'h4010_7F80, 32'h4020_0180, 32'h4030_0101, 0, 0, 1'b1);
        run_vec("R4", f_r3(2'd0, 2'b00, 5'd7), 32'h4010_7F80, 32'h4020_0180, 32'h4030_0101, 0, 0, 1'b0);
        run_vec("R4", f_r3(2'd1, 2'b00, 5'd7), 32'h7F80_0510, 32'h8001_0220, 32'h7F80_0330, 0, 0, 1'b1);
        run_vec("R4", f_r3(2'd2, 2'b00, 5'd7), 32'h8050_0A14, 32'hF0F0_0000, 32'h1010_0A0A, 0, 0, 1'b0);
        run_vec("R4", f_r3(2'd2, 2'b00, 5'h17), 32'h8000_1234, 32'hFF00_0000, 32'h0100_1000, 0, 0, 1'b0);
        // R7: forced saturation for one instruction, then back to global
        run_vec("R7", f_rr(6'd0, 2'b01, 5'd3), 32'h7F80_0102, 32'h0180_03FF, 0, 0, 0, 1'b0);
        run_vec("R7", f_rr(6'd0, 2'b00, 5'd3), 32'h7F80_0102, 32'h0180_03FF, 0, 0, 0, 1'b0);
        run_vec("R7", f_rr(6'd0, 2'b10, 5'd3), 32'h7F80_0102, 32'h0180_03FF, 0, 32'hF, 0, 1'b1);
        // R8: masks with both polarities, both widths
        run_vec("R8", f_rr(6'd0, 2'b10, 5'd3), 32'h1122_3344, 32'h0101_0101, 0, 32'hFFFF_FFF5, 32'hAABB_CCDD, 1'b0);
        run_vec("R8", f_rr(6'd0, 2'b11, 5'd3), 32'h1122_3344, 32'h0101_0101, 0, 32'hFFFF_FFF5, 32'hAABB_CCDD, 1'b0);
        run_vec("R8", f_rr(6'd0, 2'b10, 5'h13), 32'h1122_3344, 32'h0001_0001, 0, 32'h0000_0002, 32'hAABB_CCDD, 1'b0);
        run_vec("R8", f_rr(6'd0, 2'b11, 5'h13), 32'h1122_3344, 32'h0001_0001, 0, 32'h0000_0002, 32'hAABB_CCDD, 1'b0);
        // R9: undefined func codes trap without writing
        run_vec("R9", f_r3(2'd3, 2'b00, 5'd9), 32'h1, 32'h1, 32'h1, 0, 0, 1'b0);
        run_vec("R9", f_rr(6'd5, 2'b00, 5'd9), 32'h1, 32'h1, 0, 0, 0, 1'b0);
        run_vec("R9", f_ri(3'd7, 8'h01, 2'b00, 5'd9), 32'h1, 0, 0, 0, 0, 1'b0);
        // R10: strided/indexed memory encodings trap, others stay quiet
        run_vec("R10", 32'h0800_0587, 32'h1, 32'h1, 0, 0, 0, 1'b0);
        run_vec("R10", 32'h0400_05A7, 32'h1, 32'h1, 0, 0, 0, 1'b0);
        run_vec("R10", 32'h0C00_0587, 32'h1, 32'h1, 0, 0, 0, 1'b0);
        run_vec("R10", 32'h0000_0587, 32'h1, 32'h1, 0, 0, 0, 1'b0);
        run_vec("R10", 32'h0020_80B3, 32'h1, 32'h1, 0, 0, 0, 1'b0);
        // R11: back-to-back random vectors, each result one cycle later
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins, a, b, c, v1, old;
            rng = nxt(rng); ins = rng;
            if (rng[31:30] != 2'b00) ins[6:0] = 7'h57;
            if (rng[29]) ins[31:29] = {1'b0, ins[30:29]};
            rng = nxt(rng); a = rng;
            rng = nxt(rng); b = rng;
            rng = nxt(rng); c = rng;
            rng = nxt(rng); v1 = rng;
            rng = nxt(rng); old = rng;
            run_vec("R11", ins, a, b, c, v1, old, rng[7]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule